// File: doc/BRIEF.md
# Sticky Fault Flag and Alert Controller

This block collects fault events from a power converter's protection detectors and records each in a status register whose bits stay set. One active-low alert output, meant to drive an open-drain pin, goes low whenever any recorded bit is set. A host reads the record and clears it over a small register bus. Recording and alerting do not depend on any per-fault setting.

A separate suppression register decides whether a fault also raises the protective shutdown output. A response-type register chooses, per fault, between a latch-off shutdown that holds until the converter is disabled and a hiccup shutdown that releases after a fixed retry interval. Clearing all recorded bits at once is a write to a command address. Dropping the enable or supply-good input also clears the record.

The register bus uses one request channel and one response channel, each with valid/ready. A request is accepted when `req_valid_i` and `req_ready_o` are both high. `req_ready_o` stays low while a response is waiting. A response stays valid, with its data stable, until `rsp_ready_i` accepts it, so a host that holds `rsp_ready_i` low stalls further requests.

Top module: `fault_flag_ctrl`

## Requirements
- R1: A fault input high at a clock edge while enable and supply-good are both high sets the matching status bit, whether or not that fault is suppressed. The status register is read at address 0, bit i = fault i.
- R2: `alert_n_o` is 0 exactly when at least one status bit is 1, whatever the suppression settings are.
- R3: A status bit stays 1 after its fault input returns to 0, until one of the clears in R4, R5 or R6 happens.
- R4: A write to address 0 clears each status bit whose write-data bit is 1 and leaves bits written 0 unchanged. If a fault sets a bit in the same cycle as that bit is cleared, the bit stays 1.
- R5: A write of any data to address 3 clears every status bit, except bits set by a fault in that same cycle. Address 3 reads as 0.
- R6: While enable or supply-good is low, the status register is held at 0 and faults are ignored. From the next edge on, all shutdown state is released.
- R7: Suppression register at address 1 (read/write, reset 0): a bit at 1 stops the matching fault from causing shutdown. The suppression value used is the one held before the edge at which the fault is sampled.
- R8: Response-type bit at address 2 (read/write, reset 0) set to 1 selects latch-off. An unsuppressed fault then holds `shutdown_o` high from the next edge until enable or supply-good goes low.
- R9: A response-type bit of 0 selects hiccup. Each cycle the unsuppressed fault is high reloads a retry count of HICCUP_CYC. `shutdown_o` stays high for HICCUP_CYC cycles after the last such cycle and then falls.
- R10: Only one bus transaction is open at a time. `req_ready_o` = NOT `rsp_valid_o`. The response appears one cycle after acceptance and holds until `rsp_ready_i` is high. A read returns the register value from before the accepting edge. A write returns 0.
- R11: Reset (`rst_n` low) clears the status, suppression, response-type and shutdown state. After reset `alert_n_o` = 1, `shutdown_o` = 0, `rsp_valid_o` = 0 and `req_ready_o` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| en_i | input | 1 | Converter enable |
| pwr_good_i | input | 1 | Supply-good indication |
| fault_i | input | NFLT | Fault event per source, active high |
| req_valid_i | input | 1 | Bus request valid |
| req_ready_o | output | 1 | Bus request ready |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 2 | Register address |
| req_wdata_i | input | NFLT | Write data |
| rsp_valid_o | output | 1 | Response valid |
| rsp_ready_i | input | 1 | Response ready |
| rsp_rdata_o | output | NFLT | Read data (0 for writes) |
| alert_n_o | output | 1 | Active-low alert, low while any status bit is set |
| shutdown_o | output | 1 | Protective shutdown request |

## Verification
The assertions assume the host obeys the handshake. Once it raises `req_valid_i`, address, data and direction stay valid for the cycle in which it is sampled. No input changes near a clock edge. The bench drives every input half a cycle away from the active edge. It draws fault pulses sparsely, so the stretches between them exercise both persistence and clearing. Enable and supply-good drop only rarely, so the recorded state builds up before those drops clear it. Ready on the response side is randomised so that stalled responses and blocked requests both occur.

// File: rtl/ffc_pkg.sv
package ffc_pkg;
  typedef enum logic [1:0] {
    ADDR_STATUS = 2'd0,
    ADDR_SUPPR  = 2'd1,
    ADDR_RTYPE  = 2'd2,
    ADDR_CLRALL = 2'd3
  } ffc_addr_e;
endpackage

// File: rtl/ffc_regbus.sv
module ffc_regbus #(
  parameter int NFLT = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid_i,
  output logic            req_ready_o,
  input  logic            req_write_i,
  input  logic [1:0]      req_addr_i,
  input  logic [NFLT-1:0] req_wdata_i,
  output logic            rsp_valid_o,
  input  logic            rsp_ready_i,
  output logic [NFLT-1:0] rsp_rdata_o,
  input  logic [NFLT-1:0] status_i,
  output logic [NFLT-1:0] suppr_o,
  output logic [NFLT-1:0] rtype_o,
  output logic [NFLT-1:0] clr_o,
  output logic            clrall_o
);
  import ffc_pkg::*;

  logic            accept;
  logic            wr_fire;
  ffc_addr_e       addr;
  logic [NFLT-1:0] rd_mux;

  assign addr        = ffc_addr_e'(req_addr_i);
  assign req_ready_o = ~rsp_valid_o;
  assign accept      = req_valid_i & req_ready_o;
  assign wr_fire     = accept & req_write_i;
  assign clr_o       = (wr_fire && addr == ADDR_STATUS) ? req_wdata_i : '0;
  assign clrall_o    = wr_fire && addr == ADDR_CLRALL;

  always_comb begin
    case (addr)
      ADDR_STATUS: rd_mux = status_i;
      ADDR_SUPPR:  rd_mux = suppr_o;
      ADDR_RTYPE:  rd_mux = rtype_o;
      default:     rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      suppr_o     <= '0;
      rtype_o     <= '0;
      rsp_valid_o <= 1'b0;
      rsp_rdata_o <= '0;
    end else begin
      if (wr_fire && addr == ADDR_SUPPR) suppr_o <= req_wdata_i;
      if (wr_fire && addr == ADDR_RTYPE) rtype_o <= req_wdata_i;
      if (accept) begin
        rsp_valid_o <= 1'b1;
        rsp_rdata_o <= req_write_i ? '0 : rd_mux;
      end else if (rsp_ready_i) begin
        rsp_valid_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/ffc_status.sv
module ffc_status #(
  parameter int NFLT = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            act_i,
  input  logic [NFLT-1:0] fault_i,
  input  logic [NFLT-1:0] clr_i,
  input  logic            clrall_i,
  output logic [NFLT-1:0] status_o
);
  logic [NFLT-1:0] keep;
  assign keep = status_o & ~clr_i & ~{NFLT{clrall_i}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      status_o <= '0;
    else if (!act_i) status_o <= '0;
    else             status_o <= keep | fault_i;
  end
endmodule

// File: rtl/ffc_guard.sv
module ffc_guard #(
  parameter int NFLT       = 8,
  parameter int HICCUP_CYC = 1000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            act_i,
  input  logic [NFLT-1:0] fault_i,
  input  logic [NFLT-1:0] suppr_i,
  input  logic [NFLT-1:0] rtype_i,
  output logic            shutdown_o
);
  localparam int CW = $clog2(HICCUP_CYC + 1);

  logic [NFLT-1:0] trig;
  logic [NFLT-1:0] held;
  logic [NFLT-1:0] retry_busy;

  assign trig = fault_i & ~suppr_i & {NFLT{act_i}};

  for (genvar g = 0; g < NFLT; g++) begin : g_src
    logic          latch_q;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        latch_q <= 1'b0;
        cnt_q   <= '0;
      end else if (!act_i) begin
        latch_q <= 1'b0;
        cnt_q   <= '0;
      end else begin
        if (trig[g] && rtype_i[g]) latch_q <= 1'b1;
        if (trig[g] && !rtype_i[g]) cnt_q <= CW'(HICCUP_CYC);
        else if (cnt_q != '0)       cnt_q <= cnt_q - 1'b1;
      end
    end

    assign held[g]       = latch_q;
    assign retry_busy[g] = cnt_q != '0;
  end

  assign shutdown_o = |held | |retry_busy;
endmodule

// File: rtl/fault_flag_ctrl.sv
module fault_flag_ctrl #(
  parameter int NFLT       = 8,
  parameter int HICCUP_CYC = 1000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en_i,
  input  logic            pwr_good_i,
  input  logic [NFLT-1:0] fault_i,
  input  logic            req_valid_i,
  output logic            req_ready_o,
  input  logic            req_write_i,
  input  logic [1:0]      req_addr_i,
  input  logic [NFLT-1:0] req_wdata_i,
  output logic            rsp_valid_o,
  input  logic            rsp_ready_i,
  output logic [NFLT-1:0] rsp_rdata_o,
  output logic            alert_n_o,
  output logic            shutdown_o
);
  logic            act;
  logic [NFLT-1:0] status_q;
  logic [NFLT-1:0] suppr_q;
  logic [NFLT-1:0] rtype_q;
  logic [NFLT-1:0] clr;
  logic            clrall;

  assign act = en_i & pwr_good_i;

  ffc_regbus #(.NFLT(NFLT)) u_bus (
    .clk(clk), .rst_n(rst_n),
    .req_valid_i(req_valid_i), .req_ready_o(req_ready_o),
    .req_write_i(req_write_i), .req_addr_i(req_addr_i),
    .req_wdata_i(req_wdata_i), .rsp_valid_o(rsp_valid_o),
    .rsp_ready_i(rsp_ready_i), .rsp_rdata_o(rsp_rdata_o),
    .status_i(status_q), .suppr_o(suppr_q), .rtype_o(rtype_q),
    .clr_o(clr), .clrall_o(clrall)
  );

  ffc_status #(.NFLT(NFLT)) u_stat (
    .clk(clk), .rst_n(rst_n), .act_i(act), .fault_i(fault_i),
    .clr_i(clr), .clrall_i(clrall), .status_o(status_q)
  );

  ffc_guard #(.NFLT(NFLT), .HICCUP_CYC(HICCUP_CYC)) u_guard (
    .clk(clk), .rst_n(rst_n), .act_i(act), .fault_i(fault_i),
    .suppr_i(suppr_q), .rtype_i(rtype_q), .shutdown_o(shutdown_o)
  );

  assign alert_n_o = ~|status_q;
endmodule

// File: rtl/ffc_checker.sv
module ffc_checker #(
  parameter int NFLT = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            en_i,
  input logic            pwr_good_i,
  input logic [NFLT-1:0] fault_i,
  input logic [NFLT-1:0] suppr_q,
  input logic            req_valid_i,
  input logic            req_ready_o,
  input logic            req_write_i,
  input logic            rsp_valid_o,
  input logic            rsp_ready_i,
  input logic [NFLT-1:0] rsp_rdata_o,
  input logic            alert_n_o,
  input logic            shutdown_o
);
  assert_fault_alerts_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && pwr_good_i && |fault_i) |=> !alert_n_o);

  assert_alert_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!alert_n_o && en_i && pwr_good_i && !(req_valid_i && req_ready_o && req_write_i))
      |=> !alert_n_o);

  assert_inactive_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_i || !pwr_good_i) |=> (alert_n_o && !shutdown_o));

  assert_no_spurious_shutdown_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!shutdown_o && (fault_i & ~suppr_q) == '0) |=> !shutdown_o);

  assert_one_open_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid_o |-> !req_ready_o);

  assert_rsp_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid_o && !rsp_ready_i) |=> (rsp_valid_o && $stable(rsp_rdata_o)));
endmodule

bind fault_flag_ctrl ffc_checker #(.NFLT(NFLT)) u_chk (
  .clk(clk), .rst_n(rst_n), .en_i(en_i), .pwr_good_i(pwr_good_i),
  .fault_i(fault_i), .suppr_q(suppr_q), .req_valid_i(req_valid_i),
  .req_ready_o(req_ready_o), .req_write_i(req_write_i),
  .rsp_valid_o(rsp_valid_o), .rsp_ready_i(rsp_ready_i),
  .rsp_rdata_o(rsp_rdata_o), .alert_n_o(alert_n_o), .shutdown_o(shutdown_o)
);

// File: tb/sim_fault_flag_ctrl.sv
`timescale 1ns/1ps
module sim_fault_flag_ctrl;
  localparam int N  = 8;
  localparam int HC = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b1, pg = 1'b1;
  logic [N-1:0] flt = '0;
  logic rq_v = 1'b0, rq_w = 1'b0, rs_r = 1'b1;
  logic [1:0] rq_a = '0;
  logic [N-1:0] rq_d = '0;
  logic rq_rdy, rs_v, al_n, sd;
  logic [N-1:0] rs_d;

  always #2.5 clk = ~clk;

  fault_flag_ctrl #(.NFLT(N), .HICCUP_CYC(HC)) u0 (
    .clk(clk), .rst_n(rst_n), .en_i(en), .pwr_good_i(pg), .fault_i(flt),
    .req_valid_i(rq_v), .req_ready_o(rq_rdy), .req_write_i(rq_w),
    .req_addr_i(rq_a), .req_wdata_i(rq_d), .rsp_valid_o(rs_v),
    .rsp_ready_i(rs_r), .rsp_rdata_o(rs_d), .alert_n_o(al_n), .shutdown_o(sd)
  );

  // reference state
  logic [N-1:0] m_st, m_su, m_ty, m_la, m_rd;
  logic m_rv;
  int   m_cnt [N];
  int   n_vec = 0, n_bad = 0;

  task automatic model_reset();
    m_st = '0; m_su = '0; m_ty = '0; m_la = '0; m_rd = '0; m_rv = 1'b0;
    for (int i = 0; i < N; i++) m_cnt[i] = 0;
  endtask

  task automatic model_step();
    logic act, acc;
    logic [N-1:0] clr, trig, rdv, su_old, ty_old;
    if (!rst_n) begin model_reset(); return; end
    act = en & pg;
    acc = rq_v & ~m_rv;
    su_old = m_su; ty_old = m_ty;
    case (rq_a)
      2'd0: rdv = m_st;
      2'd1: rdv = m_su;
      2'd2: rdv = m_ty;
      default: rdv = '0;
    endcase
    clr = '0;
    if (acc && rq_w && rq_a == 2'd0) clr = rq_d;
    if (acc && rq_w && rq_a == 2'd3) clr = '1;
    if (acc && rq_w && rq_a == 2'd1) m_su = rq_d;
    if (acc && rq_w && rq_a == 2'd2) m_ty = rq_d;
    if (acc) begin m_rv = 1'b1; m_rd = rq_w ? '0 : rdv; end
    else if (rs_r) m_rv = 1'b0;
    trig = flt & ~su_old & {N{act}};
    if (!act) begin
      m_st = '0; m_la = '0;
      for (int i = 0; i < N; i++) m_cnt[i] = 0;
    end else begin
      m_st = (m_st & ~clr) | flt;
      m_la = m_la | (trig & ty_old);
      for (int i = 0; i < N; i++) begin
        if (trig[i] && !ty_old[i]) m_cnt[i] = HC;
        else if (m_cnt[i] > 0) m_cnt[i] = m_cnt[i] - 1;
      end
    end
  endtask

  function automatic logic exp_sd();
    logic s = |m_la;
    for (int i = 0; i < N; i++) if (m_cnt[i] != 0) s = 1'b1;
    return s;
  endfunction

  task automatic compare(input string tag);
    logic bad = 1'b0;
    n_vec++;
    if (al_n !== (m_st == '0)) begin
      bad = 1'b1; $display("FAIL %s alert_n got %b exp %b", tag, al_n, (m_st == '0));
    end
    if (sd !== exp_sd()) begin
      bad = 1'b1; $display("FAIL %s shutdown got %b exp %b", tag, sd, exp_sd());
    end
    if (rs_v !== m_rv || rq_rdy !== !m_rv) begin
      bad = 1'b1; $display("FAIL %s rsp_valid/req_ready got %b/%b exp %b/%b",
                           tag, rs_v, rq_rdy, m_rv, !m_rv);
    end
    if (m_rv && rs_d !== m_rd) begin
      bad = 1'b1; $display("FAIL %s rdata got %h exp %h", tag, rs_d, m_rd);
    end
    if (bad) n_bad++;
  endtask

  task automatic tick(input string tag);
    @(posedge clk); model_step();
    @(negedge clk); compare(tag);
  endtask

  task automatic bus(input logic w, input logic [1:0] a, input logic [N-1:0] d,
                     input string tag);
    rq_v = 1'b1; rq_w = w; rq_a = a; rq_d = d;
    tick(tag);
    rq_v = 1'b0; rq_d = '0;
    tick(tag);
  endtask

  initial begin
    void'($urandom(32'd1234));
    model_reset();
    @(negedge clk);
    tick("R11"); tick("R11");
    rst_n = 1'b1;
    tick("R11");

    // suppress all, low nibble latch-off
    bus(1'b1, 2'd1, 8'hFF, "R7");
    bus(1'b1, 2'd2, 8'h0F, "R8");
    bus(1'b0, 2'd1, '0, "R10");
    // suppressed fault still records, no shutdown
    flt = 8'h20; tick("R1"); flt = '0;
    for (int i = 0; i < 5; i++) tick("R3");
    bus(1'b0, 2'd0, '0, "R1");
    bus(1'b0, 2'd3, '0, "R5");
    // clear with simultaneous set: set wins
    flt = 8'h20; bus(1'b1, 2'd0, 8'h20, "R4"); flt = '0;
    tick("R4");
    bus(1'b1, 2'd0, 8'h20, "R4");
    // clear-all
    flt = 8'h81; tick("R1"); flt = '0;
    bus(1'b1, 2'd3, 8'h00, "R5");
    // latch-off
    bus(1'b1, 2'd1, 8'h00, "R7");
    flt = 8'h02; tick("R8"); flt = '0;
    for (int i = 0; i < 25; i++) tick("R8");
    en = 1'b0; tick("R6"); tick("R6"); en = 1'b1; tick("R6");
    // hiccup
    flt = 8'h40; tick("R9"); tick("R9"); flt = '0;
    for (int i = 0; i < HC + 4; i++) tick("R9");
    // supply-good low ignores faults
    pg = 1'b0; flt = 8'hFF; tick("R6"); tick("R6");
    pg = 1'b1; flt = '0; tick("R6");
    // response stall
    rs_r = 1'b0; bus(1'b0, 2'd2, '0, "R10"); tick("R10");
    rq_v = 1'b1; tick("R10"); rs_r = 1'b1; tick("R10"); rq_v = 1'b0; tick("R10");
    tick("R2");

    for (int c = 0; c < 4000; c++) begin
      logic [N-1:0] f = '0;
      for (int b = 0; b < N; b++) if ($urandom_range(0, 13) == 0) f[b] = 1'b1;
      flt  = f;
      en   = ($urandom_range(0, 150) != 0);
      pg   = ($urandom_range(0, 150) != 0);
      rq_v = $urandom_range(0, 1);
      rq_w = $urandom_range(0, 1);
      rq_a = 2'($urandom_range(0, 3));
      rq_d = 8'($urandom);
      rs_r = ($urandom_range(0, 9) < 7);
      tick("RND");
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule